// File: doc/BRIEF.md
# ADC Conversion and Calibration Sequencer

This block is the timing core of a 12-bit successive-approximation converter, clocked by the converter's master clock. It starts a conversion when the active-low start strobe falls, and starts one of three calibration runs when the calibrate request rises. A single BUSY flag stays high for a fixed number of master-clock periods that depends on the operation. The analog side is represented by a 12-bit input code. The core samples this code when a conversion starts and presents it as the result when that conversion finishes.

A two-bit power field places the idle core in normal mode or in one of two power-down states. A start strobe given during power-down first wakes the core, and the conversion follows one clock later. After the operation finishes, the core falls back into the state that the power field selects.

Top module: `adc_seq_core`

## Requirements
- R1: When the core is idle in normal power, a falling edge on `convst_n` sampled at a clock edge raises `busy` at that same edge. `busy` then stays high for exactly 18 clock periods.
- R2: At the edge where a conversion's `busy` falls, `result` takes the value of `ain_code` sampled at the edge that started the conversion. The code is straight binary, from 0 to 4095. `result` keeps its value while `busy` is high and through every calibration.
- R3: When the core is idle, a rising edge on `cal_req` with `cal_sel` = 00 (or 11) starts a full self-calibration. `busy` rises at that edge and stays high for 125013 clock periods.
- R4: A calibration started with `cal_sel` = 01 (internal DAC plus system full-scale) keeps `busy` high for 111114 clock periods.
- R5: A calibration started with `cal_sel` = 10 (system offset) keeps `busy` high for 13899 clock periods.
- R6: A `convst_n` falling edge or a `cal_req` rising edge that arrives while `busy` is high is ignored. The running operation is not restarted or lengthened, no extra busy period follows, and the held sample is unchanged.
- R7: While the core is idle, `pm_mode` = 10 sets `pwr_state` to 01 (full power-down) and `pm_mode` = 11 sets it to 10 (partial power-down). Both 00 and 01 set it to 00 (normal). Each takes effect at the next clock edge. `pwr_state` is 00 whenever `busy` is high.
- R8: In either power-down state, a `convst_n` falling edge sets `pwr_state` to 00 at that edge. `busy` rises one edge later and then lasts 18 periods. Once the core is idle again, it returns to the state that `pm_mode` selects.
- R9: While `rst` is high, `busy` is cleared, `result` is cleared and `pwr_state` is 00.
- R10: If a `cal_req` rising edge and a `convst_n` falling edge are sampled at the same edge while the core is idle, only the calibration runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| convst_n | input | 1 | Active-low convert-start strobe |
| cal_req | input | 1 | Calibration request, acts on its rising edge |
| pm_mode | input | 2 | Power field: 00/01 normal, 10 full power-down, 11 partial power-down |
| cal_sel | input | 2 | Calibration type: 00/11 full self, 01 DAC plus full-scale, 10 offset |
| ain_code | input | 12 | Stub analog input code |
| busy | output | 1 | High while a conversion or calibration runs |
| result | output | 12 | Last conversion result, straight binary |
| pwr_state | output | 2 | 00 normal, 01 full power-down, 10 partial power-down |

## Verification
In normal mode, `busy` is due at the first sample after the strobe edge. From power-down, `busy` is due one sample later, and `pwr_state` reads 00 in between. The result becomes valid at the same edge where `busy` falls. Power-field changes are visible two samples after the field is driven. A scoreboard queues each expected busy length and result before the stimulus. The monitor then counts `busy` samples between its rise and its fall, so every operation is timed to the exact cycle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int unsigned CONV_CLKS_DEF     = 18;
    localparam int unsigned FULL_CAL_CLKS_DEF = 125013;
    localparam int unsigned DAC_CAL_CLKS_DEF  = 111114;
    localparam int unsigned OFS_CAL_CLKS_DEF  = 13899;

    typedef enum logic [1:0] {
        PWR_ON       = 2'b00,
        PWR_FULL_OFF = 2'b01,
        PWR_PART_OFF = 2'b10
    } pwr_state_e;

    typedef enum logic [1:0] {
        CAL_FULL     = 2'b00,
        CAL_DAC_FS   = 2'b01,
        CAL_OFFSET   = 2'b10,
        CAL_FULL_ALT = 2'b11
    } cal_kind_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_CONV = 2'b01,
        OP_CAL  = 2'b10
    } op_e;

    typedef struct packed {
        logic conv_fall;
        logic cal_rise;
    } edges_t;

    function automatic pwr_state_e pm_decode(input logic [1:0] pm);
        case (pm)
            2'b10:   return PWR_FULL_OFF;
            2'b11:   return PWR_PART_OFF;
            default: return PWR_ON;
        endcase
    endfunction

endpackage

// File: rtl/adc_edge_det.sv
module adc_edge_det
    import adc_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   convst_n,
    input  logic   cal_req,
    output edges_t ev
);
    logic conv_q;
    logic cal_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            conv_q <= 1'b1;
            cal_q  <= 1'b0;
        end else begin
            conv_q <= convst_n;
            cal_q  <= cal_req;
        end
    end

    always_comb begin
        ev.conv_fall = conv_q & ~convst_n;
        ev.cal_rise  = ~cal_q & cal_req;
    end
endmodule

// File: rtl/adc_pwr_ctrl.sv
module adc_pwr_ctrl
    import adc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] pm_mode,
    input  edges_t     ev,
    input  logic       busy,
    output pwr_state_e pwr_state,
    output logic       start_conv,
    output logic       start_cal
);
    logic pend_q;
    logic idle;
    logic conv_ok;
    logic wake;

    always_comb begin
        idle       = ~busy & ~pend_q;
        start_cal  = idle & ev.cal_rise;
        conv_ok    = idle & ~ev.cal_rise & ev.conv_fall;
        wake       = conv_ok & (pwr_state != PWR_ON);
        start_conv = pend_q | (conv_ok & (pwr_state == PWR_ON));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pwr_state <= PWR_ON;
            pend_q    <= 1'b0;
        end else begin
            pend_q <= wake;
            if (start_cal | wake | start_conv) begin
                pwr_state <= PWR_ON;
            end else if (idle) begin
                pwr_state <= pm_decode(pm_mode);
            end
        end
    end
endmodule

// File: rtl/adc_busy_timer.sv
module adc_busy_timer
    import adc_seq_pkg::*;
#(
    parameter int unsigned CONV_CLKS     = CONV_CLKS_DEF,
    parameter int unsigned FULL_CAL_CLKS = FULL_CAL_CLKS_DEF,
    parameter int unsigned DAC_CAL_CLKS  = DAC_CAL_CLKS_DEF,
    parameter int unsigned OFS_CAL_CLKS  = OFS_CAL_CLKS_DEF
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start_conv,
    input  logic      start_cal,
    input  cal_kind_e cal_sel,
    output logic      busy,
    output op_e       op,
    output logic      last
);
    localparam int unsigned MAX_A   = (CONV_CLKS > FULL_CAL_CLKS) ? CONV_CLKS : FULL_CAL_CLKS;
    localparam int unsigned MAX_B   = (DAC_CAL_CLKS > OFS_CAL_CLKS) ? DAC_CAL_CLKS : OFS_CAL_CLKS;
    localparam int unsigned MAX_ALL = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned CNT_W   = $clog2(MAX_ALL + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cal_load;

    always_comb begin
        case (cal_sel)
            CAL_DAC_FS: cal_load = CNT_W'(DAC_CAL_CLKS - 1);
            CAL_OFFSET: cal_load = CNT_W'(OFS_CAL_CLKS - 1);
            default:    cal_load = CNT_W'(FULL_CAL_CLKS - 1);
        endcase
    end

    assign last = busy & (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt_q <= '0;
            op    <= OP_NONE;
        end else if (start_cal) begin
            busy  <= 1'b1;
            cnt_q <= cal_load;
            op    <= OP_CAL;
        end else if (start_conv) begin
            busy  <= 1'b1;
            cnt_q <= CNT_W'(CONV_CLKS - 1);
            op    <= OP_CONV;
        end else if (busy) begin
            if (cnt_q == '0) begin
                busy <= 1'b0;
                op   <= OP_NONE;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/adc_seq_core.sv
module adc_seq_core
    import adc_seq_pkg::*;
#(
    parameter int unsigned RES_W         = 12,
    parameter int unsigned CONV_CLKS     = CONV_CLKS_DEF,
    parameter int unsigned FULL_CAL_CLKS = FULL_CAL_CLKS_DEF,
    parameter int unsigned DAC_CAL_CLKS  = DAC_CAL_CLKS_DEF,
    parameter int unsigned OFS_CAL_CLKS  = OFS_CAL_CLKS_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             convst_n,
    input  logic             cal_req,
    input  logic [1:0]       pm_mode,
    input  logic [1:0]       cal_sel,
    input  logic [RES_W-1:0] ain_code,
    output logic             busy,
    output logic [RES_W-1:0] result,
    output logic [1:0]       pwr_state
);
    edges_t            ev;
    pwr_state_e        pwr_q;
    logic              start_conv;
    logic              start_cal;
    op_e               op;
    logic              last;
    logic [RES_W-1:0]  sample_q;

    adc_edge_det u_edge (
        .clk      (clk),
        .rst      (rst),
        .convst_n (convst_n),
        .cal_req  (cal_req),
        .ev       (ev)
    );

    adc_pwr_ctrl u_pwr (
        .clk        (clk),
        .rst        (rst),
        .pm_mode    (pm_mode),
        .ev         (ev),
        .busy       (busy),
        .pwr_state  (pwr_q),
        .start_conv (start_conv),
        .start_cal  (start_cal)
    );

    adc_busy_timer #(
        .CONV_CLKS     (CONV_CLKS),
        .FULL_CAL_CLKS (FULL_CAL_CLKS),
        .DAC_CAL_CLKS  (DAC_CAL_CLKS),
        .OFS_CAL_CLKS  (OFS_CAL_CLKS)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .start_conv (start_conv),
        .start_cal  (start_cal),
        .cal_sel    (cal_kind_e'(cal_sel)),
        .busy       (busy),
        .op         (op),
        .last       (last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sample_q <= '0;
            result   <= '0;
        end else begin
            if (start_conv) begin
                sample_q <= ain_code;
            end
            if (last && (op == OP_CONV)) begin
                result <= sample_q;
            end
        end
    end

    assign pwr_state = pwr_q;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int unsigned RES_W         = 12,
    parameter int unsigned CONV_CLKS     = 18,
    parameter int unsigned FULL_CAL_CLKS = 125013,
    parameter int unsigned DAC_CAL_CLKS  = 111114,
    parameter int unsigned OFS_CAL_CLKS  = 13899
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic [RES_W-1:0] result,
    input logic [1:0]       pwr_state,
    input logic             start_conv,
    input logic             start_cal
);
    logic [31:0] run_q;

    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            run_q <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    // R1
    busy_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start_conv || start_cal));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!busy && (result == '0) && (pwr_state == 2'b00)));

    // R2
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> $stable(result));

    // R7
    awake_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (pwr_state == 2'b00));

    // R3 (also R1, R4, R5 through the allowed lengths)
    busy_length_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ((run_q == CONV_CLKS) || (run_q == FULL_CAL_CLKS) ||
                         (run_q == DAC_CAL_CLKS) || (run_q == OFS_CAL_CLKS)));
endmodule

bind adc_seq_core adc_seq_chk #(
    .RES_W         (RES_W),
    .CONV_CLKS     (CONV_CLKS),
    .FULL_CAL_CLKS (FULL_CAL_CLKS),
    .DAC_CAL_CLKS  (DAC_CAL_CLKS),
    .OFS_CAL_CLKS  (OFS_CAL_CLKS)
) u_seq_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .result     (result),
    .pwr_state  (pwr_state),
    .start_conv (start_conv),
    .start_cal  (start_cal)
);

// File: tb/adc_seq_core_tb_top.sv
module adc_seq_core_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 195000;

    typedef struct packed {
        logic [31:0] len;
        logic [11:0] res;
        logic [23:0] tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst;
    logic        convst_n;
    logic        cal_req;
    logic [1:0]  pm_mode;
    logic [1:0]  cal_sel;
    logic [1:0]  cal_sel_b;
    logic [11:0] ain;
    logic        busy_a, busy_b;
    logic [11:0] res_a, res_b;
    logic [1:0]  pwr_a, pwr_b;

    int checks = 0;
    int errors = 0;
    exp_t q_a[$];
    exp_t q_b[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    adc_seq_core dut_i (
        .clk(clk), .rst(rst), .convst_n(convst_n), .cal_req(cal_req),
        .pm_mode(pm_mode), .cal_sel(cal_sel), .ain_code(ain),
        .busy(busy_a), .result(res_a), .pwr_state(pwr_a)
    );

    adc_seq_core dut_b (
        .clk(clk), .rst(rst), .convst_n(convst_n), .cal_req(cal_req),
        .pm_mode(pm_mode), .cal_sel(cal_sel_b), .ain_code(ain),
        .busy(busy_b), .result(res_b), .pwr_state(pwr_b)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        chk(q_a.size() == 0, "R6 pending items a", q_a.size(), 0);
        chk(q_b.size() == 0, "R6 pending items b", q_b.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // scoreboard monitors: count busy samples, compare at the fall
    int   run_a = 0;
    int   run_b = 0;
    exp_t ea, eb;

    always @(negedge clk) begin
        if (rst) begin
            run_a = 0;
        end else if (busy_a) begin
            run_a++;
        end else if (run_a != 0) begin
            if (q_a.size() == 0) begin
                chk(1'b0, "R6 unexpected busy a", run_a, 0);
            end else begin
                ea = q_a.pop_front();
                chk(run_a == int'(ea.len), $sformatf("%s length a", ea.tag), run_a, int'(ea.len));
                chk(res_a == ea.res, $sformatf("R2 result a (%s)", ea.tag), int'(res_a), int'(ea.res));
            end
            run_a = 0;
        end
    end

    always @(negedge clk) begin
        if (rst) begin
            run_b = 0;
        end else if (busy_b) begin
            run_b++;
        end else if (run_b != 0) begin
            if (q_b.size() == 0) begin
                chk(1'b0, "R6 unexpected busy b", run_b, 0);
            end else begin
                eb = q_b.pop_front();
                chk(run_b == int'(eb.len), $sformatf("%s length b", eb.tag), run_b, int'(eb.len));
                chk(res_b == eb.res, $sformatf("R2 result b (%s)", eb.tag), int'(res_b), int'(eb.res));
            end
            run_b = 0;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_both(input int len, input logic [11:0] r, input logic [23:0] tag);
        exp_t e;
        e.len = len;
        e.res = r;
        e.tag = tag;
        q_a.push_back(e);
        q_b.push_back(e);
    endtask

    task automatic conv_pulse(input logic [11:0] v);
        ain      = v;
        convst_n = 1'b0;
        @(negedge clk);
        convst_n = 1'b1;
    endtask

    task automatic wait_idle();
        while (q_a.size() != 0 || q_b.size() != 0 || busy_a || busy_b) @(negedge clk);
        step(2);
    endtask

    task automatic wake_conv(input logic [11:0] v, input logic [1:0] back);
        push_both(18, v, "R8 ");
        ain      = v;
        convst_n = 1'b0;
        @(negedge clk);
        convst_n = 1'b1;
        chk(pwr_a == 2'b00, "R8 awake after strobe", pwr_a, 0);
        chk(busy_a == 1'b0, "R8 busy delayed one clock", busy_a, 0);
        @(negedge clk);
        chk(busy_a == 1'b1, "R8 busy after wake", busy_a, 1);
        wait_idle();
        chk(pwr_a == back, "R8 return to power-down", pwr_a, back);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        chk(1'b0, "R1 watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        rst = 1'b1; convst_n = 1'b1; cal_req = 1'b0; pm_mode = 2'b00;
        cal_sel = 2'b00; cal_sel_b = 2'b00; ain = '0;
        step(3);
        rst = 1'b0;
        chk(busy_a == 1'b0, "R9 busy after reset", busy_a, 0);
        chk(res_a == 12'd0, "R9 result after reset", res_a, 0);
        chk(pwr_a == 2'b00, "R9 power after reset", pwr_a, 0);

        // R1 plain conversion
        push_both(18, 12'hABC, "R1 ");
        conv_pulse(12'hABC);
        chk(busy_a == 1'b1, "R1 busy at first sample", busy_a, 1);
        wait_idle();

        // R2 code boundaries
        push_both(18, 12'h000, "R2 ");
        conv_pulse(12'h000);
        wait_idle();
        push_both(18, 12'hFFF, "R2 ");
        conv_pulse(12'hFFF);
        wait_idle();

        // R6 edges during busy are ignored
        push_both(18, 12'h123, "R6 ");
        conv_pulse(12'h123);
        step(4);
        conv_pulse(12'h456);
        cal_req = 1'b1;
        step(1);
        cal_req = 1'b0;
        wait_idle();
        chk(res_a == 12'h123, "R6 result kept", res_a, 12'h123);

        // R7 power field decode
        pm_mode = 2'b10; step(2);
        chk(pwr_a == 2'b01, "R7 full power-down", pwr_a, 1);
        pm_mode = 2'b11; step(2);
        chk(pwr_a == 2'b10, "R7 partial power-down", pwr_a, 2);
        pm_mode = 2'b01; step(2);
        chk(pwr_a == 2'b00, "R7 code 01 normal", pwr_a, 0);
        pm_mode = 2'b00; step(2);
        chk(pwr_a == 2'b00, "R7 code 00 normal", pwr_a, 0);

        // R8 wake from each power-down state
        pm_mode = 2'b10; step(2);
        wake_conv(12'h5A5, 2'b01);
        pm_mode = 2'b11; step(2);
        wake_conv(12'h3C3, 2'b10);
        pm_mode = 2'b00; step(2);

        // R10 calibration wins over simultaneous strobe (offset type)
        cal_sel = 2'b10; cal_sel_b = 2'b10;
        push_both(13899, 12'h3C3, "R10");
        ain = 12'h777; convst_n = 1'b0; cal_req = 1'b1;
        step(1);
        convst_n = 1'b1; cal_req = 1'b0;
        wait_idle();

        // R5 offset calibration alone
        push_both(13899, 12'h3C3, "R5 ");
        cal_req = 1'b1; step(1); cal_req = 1'b0;
        wait_idle();

        // R3 full self-calibration on dut_i, R4 DAC plus full-scale on dut_b
        cal_sel = 2'b00; cal_sel_b = 2'b01;
        begin
            exp_t e3, e4;
            e3.len = 125013; e3.res = 12'h3C3; e3.tag = "R3 ";
            e4.len = 111114; e4.res = 12'h3C3; e4.tag = "R4 ";
            q_a.push_back(e3);
            q_b.push_back(e4);
        end
        cal_req = 1'b1; step(1); cal_req = 1'b0;
        wait_idle();

        finish_run();
    end
endmodule